// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Bus Controller

This block sits between a synchronous host and an external pseudo-static RAM that has an asynchronous SRAM-style bus. The host presents one request at a time over a valid/ready handshake: a word address, write data, a per-byte lane mask and a read/write flag. The block turns each request into a single bus cycle. A bus cycle drives the address, active-low chip, write and output enables, active-low byte enables, and a bidirectional 16-bit data bus. When the cycle finishes, the block returns a one-cycle done pulse. For reads, the pulse carries the captured data.

All bus timing is counted in clock cycles. Each count is the ceiling of a nanosecond limit divided by the clock period parameter. Every access is chip-enable controlled: the address settles while the chip is deselected, and every access ends with a deselect gap. The array hides its refresh behind these gaps, so the chip enable is never held low for long. After reset the block keeps the chip deselected for a long power-up interval and refuses all requests during it.

Top module: `psram_ctrl`

## Requirements
- R1: From reset onward, the chip enable, write enable, output enable and both byte enables are high. `reqReady` stays low for at least ceil(200000 ns / clock period) cycles (25000 at 8 ns) after reset is released. No bus cycle starts during that interval.
- R2: A request is taken in the cycle where `reqValid` and `reqReady` are both high. `reqReady` is low in the following cycle and stays low until that access and its deselect gap have finished.
- R3: A read drives the chip enable and output enable low together, with the write enable high, for exactly the access length. The access length is the maximum of ceil(70/T), ceil(50/T), ceil(60/T) and ceil(25/T) cycles, where T is the clock period in ns: 9 cycles at 8 ns. The address equals the request address and is held stable for the whole time the chip enable is low.
- R4: Read data is returned on `doneRdata` during a single-cycle `doneValid` pulse. Mask bit 0 selects data bits 7:0 and byte enable bit 0. Mask bit 1 selects data bits 15:8 and byte enable bit 1. Lanes that are not selected return zero.
- R5: A write with a nonzero mask drives the chip enable, write enable and selected byte enables low together for exactly the access length, with the output enable high. The write enable is never low unless the chip enable and at least one byte enable are low.
- R6: A write stores only the lanes whose mask bit is 1. A write with mask 00 lowers no byte enable and no write enable, and it leaves memory unchanged.
- R7: The block drives the data bus only during a write. Driving starts when the write enable falls and ends one cycle after the write ends. The data stays stable while driven, and the block never drives while the output enable is low.
- R8: Between any two accesses, the chip enable stays high for at least ceil(15/T) cycles.
- R9: The chip enable is never low for more than ceil(40000/T) consecutive cycles, because every access ends with a deselect.
- R10: Writes also finish with a single-cycle `doneValid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Byte lane select, bit 0 = bits 7:0 |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 16 | Read data, unselected lanes zero |
| memAddr | output | 20 | Bus address |
| memData | inout | 16 | Bidirectional data bus |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memBeN | output | 2 | Byte enables, active low, bit 0 = bits 7:0 |

## Verification
The hardest state to reach from the ports is the handover between two accesses. There, the deselect gap, the end of write data hold and the start of the next output enable all fall within a few cycles of one another. The bench reaches it by issuing back-to-back requests that alternate between reads and writes. The request stays valid while ready is low, so the next cycle starts at the earliest legal point. The bench measures the shortest high run of the chip enable across the sequence. A bus model commits write data only on the edge where the write ends. This exposes a driver released too early or byte enables dropped at the wrong time, because either one corrupts the stored lanes.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  function automatic int ceilDiv(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD,
    ST_GAP
  } seqState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic ceOn;
    logic oeOn;
    logic weOn;
    logic beOn;
    logic driveOn;
    logic capture;
    logic done;
  } busCtl_t;

endpackage

// File: rtl/psram_seq.sv
module psram_seq
  import psram_ctrl_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int ACC_CYC = 9,
  parameter int GAP_CYC = 2,
  parameter int PU_CYC  = 25000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic             reqReady,
  output busCtl_t          ctl
);

  localparam int MAX_CNT = maxOf(PU_CYC, maxOf(ACC_CYC, GAP_CYC));
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  seqState_e         state;
  logic [CNT_W-1:0]  cnt;
  logic              wrQ;
  logic              anyLaneQ;

  assign reqReady = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PWRUP;
      cnt      <= '0;
      wrQ      <= 1'b0;
      anyLaneQ <= 1'b0;
    end else begin
      case (state)
        ST_PWRUP: begin
          if (cnt == CNT_W'(PU_CYC - 1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (reqValid) begin
            state    <= ST_SETUP;
            wrQ      <= reqWrite;
            anyLaneQ <= |reqMask;
          end
        end
        ST_SETUP: begin
          state <= ST_ACCESS;
          cnt   <= '0;
        end
        ST_ACCESS: begin
          if (cnt == CNT_W'(ACC_CYC - 1)) begin
            state <= ST_HOLD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          state <= ST_GAP;
          cnt   <= '0;
        end
        ST_GAP: begin
          if (cnt == CNT_W'(GAP_CYC - 1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_PWRUP;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    case (state)
      ST_IDLE: ctl.load = reqValid;
      ST_ACCESS: begin
        ctl.ceOn    = 1'b1;
        ctl.beOn    = 1'b1;
        ctl.oeOn    = !wrQ;
        ctl.weOn    = wrQ && anyLaneQ;
        ctl.driveOn = wrQ;
      end
      ST_HOLD: begin
        ctl.driveOn = wrQ;
        ctl.capture = !wrQ;
        ctl.done    = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/psram_dpath.sv
module psram_dpath
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRdata,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memBeN,
  output logic              busDrive
);

  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;

  assign memData = busDrive ? wdataQ : {DATA_W{1'bz}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr   <= '0;
      wdataQ    <= '0;
      maskQ     <= '0;
      memCeN    <= 1'b1;
      memWeN    <= 1'b1;
      memOeN    <= 1'b1;
      busDrive  <= 1'b0;
      doneValid <= 1'b0;
    end else begin
      if (ctl.load) begin
        memAddr <= reqAddr;
        wdataQ  <= reqWdata;
        maskQ   <= reqMask;
      end
      memCeN    <= !ctl.ceOn;
      memWeN    <= !ctl.weOn;
      memOeN    <= !ctl.oeOn;
      busDrive  <= ctl.driveOn;
      doneValid <= ctl.done;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        memBeN[g]            <= 1'b1;
        doneRdata[g*8 +: 8]  <= '0;
      end else begin
        memBeN[g] <= !(ctl.beOn && maskQ[g]);
        if (ctl.capture)
          doneRdata[g*8 +: 8] <= maskQ[g] ? memData[g*8 +: 8] : 8'h00;
      end
    end
  end

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 8,
  parameter int RC_NS    = 70,
  parameter int PWE_NS   = 50,
  parameter int AW_NS    = 60,
  parameter int SD_NS    = 25,
  parameter int CD_NS    = 15,
  parameter int CEMAX_NS = 40000,
  parameter int PU_NS    = 200000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  output logic                doneValid,
  output logic [DATA_W-1:0]   doneRdata,
  output logic [ADDR_W-1:0]   memAddr,
  inout  wire  [DATA_W-1:0]   memData,
  output logic                memCeN,
  output logic                memWeN,
  output logic                memOeN,
  output logic [DATA_W/8-1:0] memBeN
);

  localparam int LANES      = DATA_W / 8;
  localparam int ACC_CYC    = maxOf(maxOf(ceilDiv(RC_NS, CLK_NS), ceilDiv(PWE_NS, CLK_NS)),
                                    maxOf(ceilDiv(AW_NS, CLK_NS), ceilDiv(SD_NS, CLK_NS)));
  localparam int GAP_CYC    = ceilDiv(CD_NS, CLK_NS);
  localparam int CEMAX_CYC  = ceilDiv(CEMAX_NS, CLK_NS);
  localparam int PU_CYC     = ceilDiv(PU_NS, CLK_NS);

  busCtl_t ctl;
  logic    busDrive;

  psram_seq #(
    .LANES  (LANES),
    .ACC_CYC(ACC_CYC),
    .GAP_CYC(GAP_CYC),
    .PU_CYC (PU_CYC)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqMask (reqMask),
    .reqReady(reqReady),
    .ctl     (ctl)
  );

  psram_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqMask  (reqMask),
    .doneValid(doneValid),
    .doneRdata(doneRdata),
    .memAddr  (memAddr),
    .memData  (memData),
    .memCeN   (memCeN),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memBeN   (memBeN),
    .busDrive (busDrive)
  );

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int GAP_CYC   = 2,
  parameter int CEMAX_CYC = 5000,
  parameter int PU_CYC    = 25000
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic                doneValid,
  input logic [ADDR_W-1:0]   memAddr,
  input wire  [DATA_W-1:0]   memData,
  input logic                memCeN,
  input logic                memWeN,
  input logic                memOeN,
  input logic [DATA_W/8-1:0] memBeN,
  input logic                busDrive
);

  localparam int SR_W = $clog2(PU_CYC + 1);
  localparam int HR_W = $clog2(GAP_CYC + 2);
  localparam int LR_W = $clog2(CEMAX_CYC + 1);

  logic [SR_W-1:0] sinceRst;
  logic [HR_W-1:0] highRun;
  logic [LR_W-1:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      highRun  <= HR_W'(GAP_CYC + 1);
      lowRun   <= '0;
    end else begin
      if (sinceRst != SR_W'(PU_CYC)) sinceRst <= sinceRst + 1'b1;
      if (!memCeN) highRun <= '0;
      else if (highRun != HR_W'(GAP_CYC + 1)) highRun <= highRun + 1'b1;
      if (memCeN) lowRun <= '0;
      else if (lowRun != LR_W'(CEMAX_CYC)) lowRun <= lowRun + 1'b1;
    end
  end

  AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < SR_W'(PU_CYC)) |-> (memCeN && !reqReady)); // R1
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2
  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memCeN && memWeN)); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !$past(memCeN)) |-> $stable(memAddr)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R4
  AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memOeN && !(&memBeN))); // R5
  AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> memOeN); // R7
  AST_DRIVE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && $past(busDrive)) |-> $stable(memData)); // R7
  AST_CE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCeN) |-> (highRun >= HR_W'(GAP_CYC))); // R8
  AST_CE_MAX: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> (lowRun < LR_W'(CEMAX_CYC))); // R9

endmodule

bind psram_ctrl psram_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .GAP_CYC  (GAP_CYC),
  .CEMAX_CYC(CEMAX_CYC),
  .PU_CYC   (PU_CYC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .doneValid(doneValid),
  .memAddr  (memAddr),
  .memData  (memData),
  .memCeN   (memCeN),
  .memWeN   (memWeN),
  .memOeN   (memOeN),
  .memBeN   (memBeN),
  .busDrive (busDrive)
);

// File: tb/tb_psram_ctrl.sv
module tb_psram_ctrl;

  localparam int T_NS = 8;

  function automatic int cdiv(input int ns);
    return (ns + T_NS - 1) / T_NS;
  endfunction

  localparam int EXP_ACC = 9;   // max(ceil 70/8, 50/8, 60/8, 25/8)
  localparam int EXP_GAP = 2;   // ceil 15/8
  localparam int EXP_PU  = 25000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        doneValid;
  logic [15:0] doneRdata;
  logic [19:0] memAddr;
  wire  [15:0] memData;
  logic        memCeN, memWeN, memOeN;
  logic [1:0]  memBeN;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  psram_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .doneValid(doneValid), .doneRdata(doneRdata), .memAddr(memAddr), .memData(memData),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memBeN(memBeN)
  );

  // bus model: 256 words indexed by the low address bits
  logic [15:0] mem [256];
  logic rdEn;
  assign rdEn = !memCeN && !memOeN && memWeN;
  assign memData[7:0]  = (rdEn && !memBeN[0]) ? mem[memAddr[7:0]][7:0]  : 8'hzz;
  assign memData[15:8] = (rdEn && !memBeN[1]) ? mem[memAddr[7:0]][15:8] : 8'hzz;

  logic        wrAct, wrActQ = 0;
  logic [15:0] wrData;
  logic [1:0]  wrBe;
  logic [19:0] wrAddr, lastWrAddr = '0;
  int ceLowRun = 0, lastCeLow = 0, weLowRun = 0, lastWeLow = 0;
  int ceHighRun = 0, minGap = 1000000, weEvents = 0;
  bit seenAccess = 0, addrMoved = 0;
  logic [19:0] ceAddr;

  assign wrAct = !memCeN && !memWeN && (memBeN != 2'b11);

  always @(negedge clk) begin
    if (wrAct) begin
      wrData <= memData; wrBe <= memBeN; wrAddr <= memAddr;
    end else if (wrActQ) begin
      if (!wrBe[0]) mem[wrAddr[7:0]][7:0]  <= wrData[7:0];
      if (!wrBe[1]) mem[wrAddr[7:0]][15:8] <= wrData[15:8];
      lastWrAddr <= wrAddr;
    end
    wrActQ <= wrAct;
    if (!memWeN) weLowRun <= weLowRun + 1;
    else if (weLowRun != 0) begin lastWeLow <= weLowRun; weLowRun <= 0; weEvents <= weEvents + 1; end
    if (!memCeN) begin
      if (ceLowRun == 0) begin
        ceAddr <= memAddr;
        if (seenAccess && ceHighRun < minGap) minGap <= ceHighRun;
        seenAccess <= 1;
      end else if (memAddr != ceAddr) addrMoved <= 1;
      ceLowRun <= ceLowRun + 1; ceHighRun <= 0;
    end else begin
      if (ceLowRun != 0) begin lastCeLow <= ceLowRun; ceLowRun <= 0; end
      ceHighRun <= ceHighRun + 1;
    end
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rd);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    check("R2 ready low after accept", !reqReady, reqReady, 0);
    while (!doneValid) @(negedge clk);
    rd = doneRdata;
    @(negedge clk);
    check(wr ? "R10 write done single cycle" : "R4 done single cycle", !doneValid, doneValid, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic tReset();
    int waitCyc = 0;
    bit ceLow = 0;
    repeat (3) @(negedge clk);
    check("R1 pins high in reset", {memCeN, memWeN, memOeN, memBeN} == 5'h1f,
          {memCeN, memWeN, memOeN, memBeN}, 5'h1f);
    check("R1 ready low in reset", !reqReady, reqReady, 0);
    rstN = 1;
    while (!reqReady && waitCyc < EXP_PU + 100) begin
      @(negedge clk);
      waitCyc++;
      if (!memCeN) ceLow = 1;
    end
    check("R1 power-up wait", waitCyc >= EXP_PU && waitCyc < EXP_PU + 100, waitCyc, EXP_PU);
    check("R1 ce high during power-up", !ceLow, ceLow, 0);
  endtask

  task automatic tFullWord();
    logic [15:0] rd;
    access(1, 20'hA5C12, 16'h1234, 2'b11, rd);
    check("R5 write ce low length", lastCeLow == EXP_ACC, lastCeLow, EXP_ACC);
    check("R5 write we low length", lastWeLow == EXP_ACC, lastWeLow, EXP_ACC);
    check("R3 write address on bus", lastWrAddr == 20'hA5C12, lastWrAddr, 20'hA5C12);
    check("R7 write data landed", mem[8'h12] == 16'h1234, mem[8'h12], 16'h1234);
    access(0, 20'hA5C12, 16'h0, 2'b11, rd);
    check("R3 read ce low length", lastCeLow == EXP_ACC, lastCeLow, EXP_ACC);
    check("R4 read full word", rd == 16'h1234, rd, 16'h1234);
    check("R3 address stable under ce", !addrMoved, addrMoved, 0);
  endtask

  task automatic tByteLanes();
    logic [15:0] rd;
    access(1, 20'h00040, 16'hAAAA, 2'b11, rd);
    access(1, 20'h00040, 16'h3355, 2'b01, rd);
    access(0, 20'h00040, 16'h0, 2'b11, rd);
    check("R6 lower lane write", rd == 16'hAA55, rd, 16'hAA55);
    access(1, 20'h00040, 16'h66CC, 2'b10, rd);
    access(0, 20'h00040, 16'h0, 2'b11, rd);
    check("R6 upper lane write", rd == 16'h6655, rd, 16'h6655);
    access(0, 20'h00040, 16'h0, 2'b01, rd);
    check("R4 upper lane zero on lower read", rd == 16'h0055, rd, 16'h0055);
    access(0, 20'h00040, 16'h0, 2'b10, rd);
    check("R4 lower lane zero on upper read", rd == 16'h6600, rd, 16'h6600);
  endtask

  task automatic tNoLanes();
    logic [15:0] rd;
    int evBefore = weEvents;
    access(1, 20'h00040, 16'hFFFF, 2'b00, rd);
    check("R6 mask 00 no write pulse", weEvents == evBefore, weEvents, evBefore);
    access(0, 20'h00040, 16'h0, 2'b11, rd);
    check("R6 mask 00 leaves data", rd == 16'h6655, rd, 16'h6655);
  endtask

  task automatic tBackToBack();
    logic [15:0] rd;
    minGap = 1000000;
    fork
      begin
        for (int i = 0; i < 6; i++) begin
          reqValid = 1; reqWrite = i[0]; reqAddr = 20'h0_0080 + 20'(i);
          reqWdata = 16'h0F00 + 16'(i); reqMask = 2'b11;
          @(negedge clk);
          while (!reqReady) @(negedge clk);
          @(posedge clk);
          #1;
        end
        reqValid = 0;
      end
    join
    repeat (30) @(negedge clk);
    check("R8 minimum deselect gap", minGap >= EXP_GAP, minGap, EXP_GAP);
    access(0, 20'h00085, 16'h0, 2'b11, rd);
    check("R7 back-to-back write data", rd == 16'h0F05, rd, 16'h0F05);
    check("R9 ce low run bounded", lastCeLow <= cdiv(40000), lastCeLow, cdiv(40000));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    tReset();
    tFullWord();
    tByteLanes();
    tNoLanes();
    tBackToBack();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule